// File: doc/BRIEF.md
# Relative Jump Next-PC Unit

This block works out the program counter that follows a relative jump in a 16-bit processor. The sequencer hands it an instruction word, a program counter that fetch has already advanced past that word, and the four status flags. The block decides whether the word belongs to the jump group. For a jump it tests one of eight branch conditions against the flags. It then produces either the jump target or the incremented PC unchanged.

The jump offset is a signed count of 16-bit words held in the low ten bits of the instruction. The block sign-extends it, doubles it to a byte distance and adds it to the incremented PC. Each jump takes the unit through two busy cycles, whether the branch is taken or not, so the sequencer sees the same timing every time. A word outside the jump group needs one cycle: the incremented PC comes back and busy is never raised. New instructions offered while the unit is busy are dropped.

Top module: `rel_jump_unit`

## Requirements
- R1: After a synchronous active-high reset, `npc_o` is 0 and `npc_vld_o` and `busy_o` are both low.
- R2: An accepted word whose bits [15:13] are not 001 is not a jump. On the next cycle `npc_vld_o` is high for one cycle and `npc_o` equals `pc_inc_i` with bit 0 cleared. `busy_o` stays low, so such words may be issued on consecutive cycles.
- R3: For a jump, bits [12:10] select the condition. The flags are read as `flags_i` bit 0 = carry, bit 1 = zero, bit 2 = negative, bit 3 = overflow. The codes are: 0 = zero clear, 1 = zero set, 2 = carry clear, 3 = carry set, 4 = negative set, 5 = negative equals overflow, 6 = negative differs from overflow, 7 = always.
- R4: A taken jump yields `pc_inc_i` + 2 × (bits [9:0] sign-extended as two's complement), modulo 2^16.
- R5: A jump whose condition is false yields `pc_inc_i` with bit 0 cleared.
- R6: Every accepted jump raises `busy_o` for exactly the two cycles after the issue edge. `npc_vld_o` is high in the second of them only, whether or not the jump is taken.
- R7: `issue_i` is ignored while `busy_o` is high. `npc_o` and the jump's timing are unaffected.
- R8: Bit 0 of `npc_o` is always 0, even when `pc_inc_i` is odd.
- R9: `npc_o` holds its last result until the next accepted issue replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Offer of an instruction word for evaluation |
| ir_i | input | 16 | Instruction word |
| pc_inc_i | input | 16 | PC already advanced past the instruction |
| flags_i | input | 4 | Status flags {overflow, negative, zero, carry} |
| npc_o | output | 16 | Next program counter |
| npc_vld_o | output | 1 | `npc_o` carries a fresh result this cycle |
| busy_o | output | 1 | Jump in progress; issues are dropped |

## Verification
The hardest case to reach is an issue that arrives in the middle of a jump. If it were accepted, it would overwrite the target or restart the two-cycle window. The bench drives a jump and, in the first busy cycle, raises `issue_i` with a non-jump word and a different PC. It keeps that request held into the second busy cycle. It then checks that the jump's own target appears on time and that nothing follows. Conditions are covered by running every code against all sixteen flag combinations. The extreme positive and negative offsets and a wraparound past the top of the address space are also driven.

// File: rtl/rju_pkg.sv
package rju_pkg;

    localparam int RJU_PC_W   = 16;
    localparam int RJU_OFF_W  = 10;
    localparam int RJU_GRP_W  = 3;
    localparam int RJU_COND_W = 3;

    // flag vector layout, bit 0 is carry
    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [RJU_COND_W-1:0] {
        CND_NZ = 3'd0,
        CND_Z  = 3'd1,
        CND_NC = 3'd2,
        CND_C  = 3'd3,
        CND_N  = 3'd4,
        CND_GE = 3'd5,
        CND_LT = 3'd6,
        CND_AL = 3'd7
    } cond_e;

    typedef struct packed {
        logic  is_jump;
        cond_e cond;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_J1   = 2'd2,
        ST_J2   = 2'd3
    } state_e;

    function automatic logic cond_met(input cond_e cc, input flags_t f);
        logic r;
        case (cc)
            CND_NZ:  r = ~f.z;
            CND_Z:   r = f.z;
            CND_NC:  r = ~f.c;
            CND_C:   r = f.c;
            CND_N:   r = f.n;
            CND_GE:  r = ~(f.n ^ f.v);
            CND_LT:  r = f.n ^ f.v;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rju_decode.sv
module rju_decode
    import rju_pkg::*;
#(
    parameter int                 IR_W    = 16,
    parameter int                 OFF_W   = RJU_OFF_W,
    parameter int                 GRP_W   = RJU_GRP_W,
    parameter logic [GRP_W-1:0]   GRP_VAL = 3'b001
) (
    input  logic [IR_W-1:0]  ir_i,
    output dec_t             dec_o,
    output logic [OFF_W-1:0] off_o
);
    localparam int COND_LSB = OFF_W;
    localparam int COND_MSB = OFF_W + RJU_COND_W - 1;
    localparam int GRP_LSB  = IR_W - GRP_W;

    logic [GRP_W-1:0]      grp;
    logic [RJU_COND_W-1:0] cfield;

    assign grp           = ir_i[IR_W-1:GRP_LSB];
    assign cfield        = ir_i[COND_MSB:COND_LSB];
    assign off_o         = ir_i[OFF_W-1:0];
    assign dec_o.is_jump = (grp == GRP_VAL);
    assign dec_o.cond    = cond_e'(cfield);

endmodule

// File: rtl/rju_cond.sv
module rju_cond
    import rju_pkg::*;
(
    input  dec_t   dec_i,
    input  flags_t flags_i,
    output logic   take_o
);
    logic hit;

    assign hit    = cond_met(dec_i.cond, flags_i);
    assign take_o = dec_i.is_jump & hit;

endmodule

// File: rtl/rju_target.sv
module rju_target #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 10
) (
    input  logic [PC_W-1:0]  pc_inc_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             take_i,
    output logic [PC_W-1:0]  npc_o
);
    localparam int HI_W = PC_W - 1;

    // offset in words, widened to the word-address width
    logic [HI_W-1:0] ext_w;
    logic [HI_W-1:0] sum_hi;

    generate
        if (HI_W > OFF_W) begin : g_sext
            assign ext_w = {{(HI_W-OFF_W){off_i[OFF_W-1]}}, off_i};
        end else begin : g_trunc
            assign ext_w = off_i[HI_W-1:0];
        end
    endgenerate

    assign sum_hi = pc_inc_i[PC_W-1:1] + ext_w;
    assign npc_o  = take_i ? {sum_hi, 1'b0} : {pc_inc_i[PC_W-1:1], 1'b0};

endmodule

// File: rtl/rel_jump_unit.sv
module rel_jump_unit
    import rju_pkg::*;
#(
    parameter int PC_W  = RJU_PC_W,
    parameter int OFF_W = RJU_OFF_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_i,
    input  logic [15:0]     ir_i,
    input  logic [PC_W-1:0] pc_inc_i,
    input  logic [3:0]      flags_i,
    output logic [PC_W-1:0] npc_o,
    output logic            npc_vld_o,
    output logic            busy_o
);
    localparam int IR_W = RJU_GRP_W + RJU_COND_W + OFF_W;

    dec_t            dec;
    logic [OFF_W-1:0] off;
    logic            take;
    logic [PC_W-1:0] npc_calc;
    logic            accept;
    state_e          state;
    logic [PC_W-1:0] npc_q;

    rju_decode #(.IR_W(IR_W), .OFF_W(OFF_W)) u_dec (
        .ir_i  (ir_i),
        .dec_o (dec),
        .off_o (off)
    );

    rju_cond u_cond (
        .dec_i   (dec),
        .flags_i (flags_t'(flags_i)),
        .take_o  (take)
    );

    // R3 unconditional code always takes the branch
    always_comb begin
        if (dec.is_jump && dec.cond == CND_AL)
            always_take_chk: assert (take || $isunknown(flags_i));
    end

    rju_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc_inc_i (pc_inc_i),
        .off_i    (off),
        .take_i   (take),
        .npc_o    (npc_calc)
    );

    assign busy_o    = (state == ST_J1) || (state == ST_J2);
    assign npc_vld_o = (state == ST_J2) || (state == ST_PASS);
    assign accept    = issue_i && !busy_o;
    assign npc_o     = npc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            npc_q <= '0;
        end else if (accept) begin
            npc_q <= npc_calc;
            state <= dec.is_jump ? ST_J1 : ST_PASS;
        end else begin
            case (state)
                ST_J1:   state <= ST_J2;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6
    // busy lasts at least two cycles
    busy_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> busy_o);

    // R6
    busy_max_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |=> !busy_o);

    // R6
    vld_second_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> npc_vld_o);

    // R2
    pass_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec.is_jump) |=> (npc_vld_o && !busy_o));

    // R8
    even_pc_chk: assert property (@(posedge clk) disable iff (rst)
        npc_vld_o |-> !npc_o[0]);

    // R8
    odd_in_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && pc_inc_i[0]) |=> !npc_o[0]);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(npc_o));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(accept) && !$past(rst)) |-> $stable(npc_o));

endmodule

// File: tb/tb_rel_jump_unit.sv
module tb_rel_jump_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_i;
    logic [15:0] ir_i;
    logic [15:0] pc_inc_i;
    logic [3:0]  flags_i;
    logic [15:0] npc_o;
    logic        npc_vld_o;
    logic        busy_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rel_jump_unit dut (
        .clk       (clk),
        .rst       (rst),
        .issue_i   (issue_i),
        .ir_i      (ir_i),
        .pc_inc_i  (pc_inc_i),
        .flags_i   (flags_i),
        .npc_o     (npc_o),
        .npc_vld_o (npc_vld_o),
        .busy_o    (busy_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // independent model of the requirements
    function automatic logic model_take(input logic [2:0] cc, input logic [3:0] f);
        logic c, z, n, v;
        c = f[0]; z = f[1]; n = f[2]; v = f[3];
        case (cc)
            3'd0: return !z;
            3'd1: return z;
            3'd2: return !c;
            3'd3: return c;
            3'd4: return n;
            3'd5: return n == v;
            3'd6: return n != v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] model_npc(input logic [15:0] ir, input logic [15:0] pc,
                                              input logic [3:0] f);
        logic [15:0] d;
        if (ir[15:13] == 3'b001 && model_take(ir[12:10], f)) begin
            d = {{5{ir[9]}}, ir[9:0], 1'b0};
            return (pc + d) & 16'hFFFE;
        end
        return pc & 16'hFFFE;
    endfunction

    task automatic run_jump(input string tag, input logic [15:0] ir, input logic [15:0] pc,
                            input logic [3:0] f);
        logic [15:0] e;
        e = model_npc(ir, pc, f);
        issue_i = 1'b1; ir_i = ir; pc_inc_i = pc; flags_i = f;
        @(negedge clk);
        issue_i = 1'b0;
        chk({tag, " R6 busy c1"}, 16'(busy_o), 16'd1);
        chk({tag, " R6 vld c1"}, 16'(npc_vld_o), 16'd0);
        @(negedge clk);
        chk({tag, " R6 busy c2"}, 16'(busy_o), 16'd1);
        chk({tag, " R6 vld c2"}, 16'(npc_vld_o), 16'd1);
        chk({tag, " R4/R5 npc"}, npc_o, e);
        @(negedge clk);
        chk({tag, " R6 idle"}, {14'd0, busy_o, npc_vld_o}, 16'd0);
        chk({tag, " R9 hold"}, npc_o, e);
    endtask

    task automatic t_reset();
        rst = 1'b1; issue_i = 1'b0; ir_i = '0; pc_inc_i = '0; flags_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 npc", npc_o, 16'h0000);
        chk("R1 vld", 16'(npc_vld_o), 16'd0);
        chk("R1 busy", 16'(busy_o), 16'd0);
    endtask

    task automatic t_conditions();
        for (int cc = 0; cc < 8; cc++) begin
            for (int f = 0; f < 16; f++) begin
                run_jump($sformatf("R3 cc=%0d f=%0h", cc, f),
                         {3'b001, 3'(cc), 10'h005}, 16'h4000, 4'(f));
            end
        end
    endtask

    task automatic t_offsets();
        run_jump("R4 max fwd", {3'b001, 3'd7, 10'h1FF}, 16'h8000, 4'h0);
        chk("R4 max fwd value", npc_o, 16'h83FE);
        run_jump("R4 max back", {3'b001, 3'd7, 10'h200}, 16'h8000, 4'h0);
        chk("R4 max back value", npc_o, 16'h7C00);
        run_jump("R4 self", {3'b001, 3'd7, 10'h3FF}, 16'h1002, 4'h0);
        chk("R4 minus one word", npc_o, 16'h1000);
        run_jump("R4 wrap", {3'b001, 3'd7, 10'h004}, 16'hFFFE, 4'h0);
        chk("R4 wrap value", npc_o, 16'h0006);
        run_jump("R5 not taken", {3'b001, 3'd1, 10'h100}, 16'h2222, 4'h0);
        chk("R5 value", npc_o, 16'h2222);
    endtask

    task automatic t_passthru();
        issue_i = 1'b1; ir_i = 16'h4031; pc_inc_i = 16'h8004; flags_i = 4'hF;
        @(negedge clk);
        chk("R2 vld", 16'(npc_vld_o), 16'd1);
        chk("R2 busy", 16'(busy_o), 16'd0);
        chk("R2 npc", npc_o, 16'h8004);
        ir_i = 16'h5A3C; pc_inc_i = 16'h1235;
        @(negedge clk);
        issue_i = 1'b0;
        chk("R2 back-to-back", npc_o, 16'h1234);
        chk("R8 odd pc cleared", 16'(npc_o[0]), 16'd0);
        @(negedge clk);
        chk("R9 vld drops", 16'(npc_vld_o), 16'd0);
        chk("R9 npc held", npc_o, 16'h1234);
    endtask

    task automatic t_odd_jump();
        run_jump("R8 odd taken", {3'b001, 3'd7, 10'h010}, 16'h3001, 4'h0);
        chk("R8 odd taken value", npc_o, 16'h3020);
    endtask

    task automatic t_busy_drop();
        issue_i = 1'b1; ir_i = {3'b001, 3'd7, 10'h008}; pc_inc_i = 16'h0100; flags_i = 4'h0;
        @(negedge clk);
        ir_i = 16'h4000; pc_inc_i = 16'hBEEE;
        chk("R7 busy c1", 16'(busy_o), 16'd1);
        @(negedge clk);
        issue_i = 1'b0;
        chk("R7 vld c2", 16'(npc_vld_o), 16'd1);
        chk("R7 target kept", npc_o, 16'h0110);
        @(negedge clk);
        chk("R7 no extra result", {14'd0, busy_o, npc_vld_o}, 16'd0);
        chk("R7 npc unchanged", npc_o, 16'h0110);
    endtask

    initial begin
        t_reset();
        t_conditions();
        t_offsets();
        t_passthru();
        t_odd_jump();
        t_busy_drop();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule